// File: doc/BRIEF.md
# Global Configuration Controller

This block sits behind a serial debug front end and turns its command words into traffic toward a configurable fabric. Each command carries an operation code, an address field and a data field. The controller decodes the code and then does one of four things. It can run a configuration read or write with strobes toward the fabric. It can read or write one of its own control registers. It can place a fixed bring-up constant on the return path. It can run a timed sequence that releases stall on selected clock domains, or that pulses a global reset. Results come back on a single return-data output.

Read and write strobe lengths are set at run time by a delay register. The controller can release stall on a masked subset of domains for a programmed number of cycles and then restore the stored stall mask by itself. While any multi-cycle operation runs, a busy output is high and new operation codes are ignored. An operation code is accepted on the clock edge where it is non-zero and busy is low.

Top module: `gcfg_ctrl`

## Requirements
- R1: Operation codes (5 bits) are: 0 no-op, 1 bring-up, 2 config write, 3 config read, 4/5 test register write/read, 6/7 stall write/read, 8/9 clock-select write/read, 10/11 strobe-delay write/read, 12/13 switch-delay write/read, 14 advance clock, 15 global reset. Codes 16–31 act as no-ops. Codes presented while busy is high have no effect.
- R2: The bring-up code puts 0x0000A050 on the return-data output at the accepting edge and does not raise busy.
- R3: A config write with effective delay N drives the write strobe high for N cycles from the accepting edge, then low for one more cycle with busy still high, for N+1 busy cycles. The read strobe stays low, and address and write data hold the supplied values.
- R4: A config read drives the read strobe high for N cycles from the accepting edge with the supplied address, then low for one cycle. At the edge that ends that cycle, the fabric read data is captured on the return-data output and busy falls.
- R5: A stall write changes the stall output at the accepting edge, in a single cycle without busy.
- R6: Advance clock with mask M (address bits 3:0) and duration D forces stall to 0 on the domains whose bit in M is set, for D cycles, with the other domains unchanged. In the next cycle the stored stall mask is back on the output. Busy is high for D+1 cycles.
- R7: Global reset with duration D (data field) holds the reset output high for D cycles, then low for one more busy cycle.
- R8: Each control register read returns the last written value, zero-extended, on the return-data output at the accepting edge. Register widths are: test 32, stall 4, clock-select 1, strobe delay 5, switch delay 1. Written values are truncated to these widths and are also visible on the matching outputs.
- R9: After reset: stall output 4'b1111, strobe delay 1, test, clock-select and switch-delay 0, return data 0, all strobes and busy low.
- R10: The read and write strobes are never high together, and no strobe or reset output is high while busy is low.
- R11: A strobe delay or duration of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all registers |
| op_i | input | 5 | Operation code |
| addr_i | input | 32 | Address / domain-mask field |
| data_i | input | 32 | Data / duration field |
| cfg_rdata_i | input | 32 | Read data from the fabric |
| busy_o | output | 1 | Multi-cycle operation in progress |
| jtag_rdata_o | output | 32 | Return data toward the front end |
| cfg_rd_o | output | 1 | Fabric read strobe |
| cfg_wr_o | output | 1 | Fabric write strobe |
| cfg_addr_o | output | 32 | Fabric address |
| cfg_wdata_o | output | 32 | Fabric write data |
| stall_o | output | 4 | Per-domain stall |
| clk_sel_o | output | 1 | Clock-select register |
| rw_dly_o | output | 5 | Strobe delay register |
| sw_dly_o | output | 1 | Clock-switch delay register |
| greset_o | output | 1 | Global reset output |

## Verification
The assertions assume that reset is applied at the start and that the fabric read data is a plain level input. They place no limits on the operation code, because the block has to ignore anything presented while busy. The stimulus presents each code for exactly one cycle while busy is low. It keeps durations and delays small so that whole sequences can be observed. One directed case deliberately drives a code during a running write to show that it is dropped.

// File: rtl/gcfg_pkg.sv
package gcfg_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_NOP       = 5'd0,
        OP_BRINGUP   = 5'd1,
        OP_CFG_WR    = 5'd2,
        OP_CFG_RD    = 5'd3,
        OP_TST_WR    = 5'd4,
        OP_TST_RD    = 5'd5,
        OP_STALL_WR  = 5'd6,
        OP_STALL_RD  = 5'd7,
        OP_CKSEL_WR  = 5'd8,
        OP_CKSEL_RD  = 5'd9,
        OP_RWDLY_WR  = 5'd10,
        OP_RWDLY_RD  = 5'd11,
        OP_SWDLY_WR  = 5'd12,
        OP_SWDLY_RD  = 5'd13,
        OP_ADV_CLK   = 5'd14,
        OP_GRESET    = 5'd15
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_RD,
        ST_ADV,
        ST_RST,
        ST_TAIL,
        ST_RD_TAIL
    } state_e;

    localparam logic [15:0] BRINGUP_WORD = 16'hA050;

endpackage

// File: rtl/gcfg_decode.sv
module gcfg_decode
    import gcfg_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output op_e             op_o,
    output logic            valid_o
);
    always_comb begin
        op_o    = OP_NOP;
        valid_o = 1'b0;
        case (op_i)
            5'd1:  begin op_o = OP_BRINGUP;  valid_o = 1'b1; end
            5'd2:  begin op_o = OP_CFG_WR;   valid_o = 1'b1; end
            5'd3:  begin op_o = OP_CFG_RD;   valid_o = 1'b1; end
            5'd4:  begin op_o = OP_TST_WR;   valid_o = 1'b1; end
            5'd5:  begin op_o = OP_TST_RD;   valid_o = 1'b1; end
            5'd6:  begin op_o = OP_STALL_WR; valid_o = 1'b1; end
            5'd7:  begin op_o = OP_STALL_RD; valid_o = 1'b1; end
            5'd8:  begin op_o = OP_CKSEL_WR; valid_o = 1'b1; end
            5'd9:  begin op_o = OP_CKSEL_RD; valid_o = 1'b1; end
            5'd10: begin op_o = OP_RWDLY_WR; valid_o = 1'b1; end
            5'd11: begin op_o = OP_RWDLY_RD; valid_o = 1'b1; end
            5'd12: begin op_o = OP_SWDLY_WR; valid_o = 1'b1; end
            5'd13: begin op_o = OP_SWDLY_RD; valid_o = 1'b1; end
            5'd14: begin op_o = OP_ADV_CLK;  valid_o = 1'b1; end
            5'd15: begin op_o = OP_GRESET;   valid_o = 1'b1; end
            default: begin op_o = OP_NOP;    valid_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/gcfg_timer.sv
module gcfg_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            // zero length runs like one
            cnt_d = (len_i == '0) ? '0 : len_i - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == '0);
endmodule

// File: rtl/gcfg_ctrl.sv
module gcfg_ctrl
    import gcfg_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int NDOM  = 4,
    parameter int DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    data_i,
    input  logic [DW-1:0]    cfg_rdata_i,
    output logic             busy_o,
    output logic [DW-1:0]    jtag_rdata_o,
    output logic             cfg_rd_o,
    output logic             cfg_wr_o,
    output logic [AW-1:0]    cfg_addr_o,
    output logic [DW-1:0]    cfg_wdata_o,
    output logic [NDOM-1:0]  stall_o,
    output logic             clk_sel_o,
    output logic [DLY_W-1:0] rw_dly_o,
    output logic             sw_dly_o,
    output logic             greset_o
);
    localparam int CNT_W = DW;

    typedef struct packed {
        state_e           state;
        logic [DW-1:0]    test;
        logic [NDOM-1:0]  stall;
        logic [NDOM-1:0]  stall_out;
        logic             clk_sel;
        logic [DLY_W-1:0] rw_dly;
        logic             sw_dly;
        logic             rd;
        logic             wr;
        logic             grst;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    jdata;
    } ctrl_t;

    ctrl_t            c_d, c_q;
    op_e              dec_op;
    logic             dec_valid;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_last;

    gcfg_decode u_decode (
        .op_i    (op_i),
        .op_o    (dec_op),
        .valid_o (dec_valid)
    );

    gcfg_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .last_o (tmr_last)
    );

    always_comb begin
        c_d      = c_q;
        tmr_load = 1'b0;
        tmr_len  = CNT_W'(c_q.rw_dly);
        case (c_q.state)
            ST_IDLE: begin
                if (dec_valid) begin
                    case (dec_op)
                        OP_BRINGUP:  c_d.jdata = DW'(BRINGUP_WORD);
                        OP_CFG_WR: begin
                            c_d.wr    = 1'b1;
                            c_d.addr  = addr_i;
                            c_d.wdata = data_i;
                            tmr_load  = 1'b1;
                            c_d.state = ST_WR;
                        end
                        OP_CFG_RD: begin
                            c_d.rd    = 1'b1;
                            c_d.addr  = addr_i;
                            tmr_load  = 1'b1;
                            c_d.state = ST_RD;
                        end
                        OP_TST_WR:   c_d.test  = data_i;
                        OP_TST_RD:   c_d.jdata = c_q.test;
                        OP_STALL_WR: begin
                            c_d.stall     = data_i[NDOM-1:0];
                            c_d.stall_out = data_i[NDOM-1:0];
                        end
                        OP_STALL_RD: c_d.jdata = DW'(c_q.stall);
                        OP_CKSEL_WR: c_d.clk_sel = data_i[0];
                        OP_CKSEL_RD: c_d.jdata = DW'(c_q.clk_sel);
                        OP_RWDLY_WR: c_d.rw_dly = data_i[DLY_W-1:0];
                        OP_RWDLY_RD: c_d.jdata = DW'(c_q.rw_dly);
                        OP_SWDLY_WR: c_d.sw_dly = data_i[0];
                        OP_SWDLY_RD: c_d.jdata = DW'(c_q.sw_dly);
                        OP_ADV_CLK: begin
                            c_d.stall_out = c_q.stall & ~addr_i[NDOM-1:0];
                            tmr_len       = data_i;
                            tmr_load      = 1'b1;
                            c_d.state     = ST_ADV;
                        end
                        OP_GRESET: begin
                            c_d.grst  = 1'b1;
                            tmr_len   = data_i;
                            tmr_load  = 1'b1;
                            c_d.state = ST_RST;
                        end
                        default: ;
                    endcase
                end
            end
            ST_WR, ST_RD, ST_ADV, ST_RST: begin
                if (tmr_last) begin
                    c_d.wr        = 1'b0;
                    c_d.rd        = 1'b0;
                    c_d.grst      = 1'b0;
                    c_d.stall_out = c_q.stall;
                    c_d.state     = (c_q.state == ST_RD) ? ST_RD_TAIL : ST_TAIL;
                end
            end
            ST_RD_TAIL: begin
                c_d.jdata = cfg_rdata_i;
                c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q           <= '0;
            c_q.state     <= ST_IDLE;
            c_q.stall     <= '1;
            c_q.stall_out <= '1;
            c_q.rw_dly    <= DLY_W'(1);
        end else begin
            c_q <= c_d;
        end
    end

    assign busy_o       = (c_q.state != ST_IDLE);
    assign jtag_rdata_o = c_q.jdata;
    assign cfg_rd_o     = c_q.rd;
    assign cfg_wr_o     = c_q.wr;
    assign cfg_addr_o   = c_q.addr;
    assign cfg_wdata_o  = c_q.wdata;
    assign stall_o      = c_q.stall_out;
    assign clk_sel_o    = c_q.clk_sel;
    assign rw_dly_o     = c_q.rw_dly;
    assign sw_dly_o     = c_q.sw_dly;
    assign greset_o     = c_q.grst;
endmodule

// File: rtl/gcfg_ctrl_chk.sv
module gcfg_ctrl_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic          cfg_rd_o,
    input logic          cfg_wr_o,
    input logic [AW-1:0] cfg_addr_o,
    input logic [DW-1:0] cfg_wdata_o,
    input logic          greset_o
);
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_rd_o && cfg_wr_o));

    assert_strobe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_o || cfg_wr_o || greset_o) |-> busy_o);

    assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_o && $past(cfg_wr_o)) |-> ($stable(cfg_addr_o) && $stable(cfg_wdata_o)));

    assert_wr_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_wr_o) |-> busy_o ##1 !busy_o);

    assert_rd_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_rd_o) |-> busy_o ##1 !busy_o);

    assert_rst_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(greset_o) |-> busy_o ##1 !busy_o);
endmodule

bind gcfg_ctrl gcfg_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .cfg_rd_o    (cfg_rd_o),
    .cfg_wr_o    (cfg_wr_o),
    .cfg_addr_o  (cfg_addr_o),
    .cfg_wdata_o (cfg_wdata_o),
    .greset_o    (greset_o)
);

// File: tb/gcfg_ctrl_test.sv
module gcfg_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_i = '0;
    logic [31:0] addr_i = '0, data_i = '0, cfg_rdata_i = '0;
    logic        busy_o, cfg_rd_o, cfg_wr_o, clk_sel_o, sw_dly_o, greset_o;
    logic [31:0] jtag_rdata_o, cfg_addr_o, cfg_wdata_o;
    logic [3:0]  stall_o;
    logic [4:0]  rw_dly_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] m_tst = 0;
    logic [3:0]  m_stall = 4'hF;
    logic        m_cksel = 0, m_swdly = 0;
    logic [4:0]  m_dly = 5'd1;

    always #2 clk = ~clk;

    gcfg_ctrl uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i), .data_i(data_i),
        .cfg_rdata_i(cfg_rdata_i), .busy_o(busy_o), .jtag_rdata_o(jtag_rdata_o),
        .cfg_rd_o(cfg_rd_o), .cfg_wr_o(cfg_wr_o), .cfg_addr_o(cfg_addr_o),
        .cfg_wdata_o(cfg_wdata_o), .stall_o(stall_o), .clk_sel_o(clk_sel_o),
        .rw_dly_o(rw_dly_o), .sw_dly_o(sw_dly_o), .greset_o(greset_o)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one op for the next edge; returns at negedge after accepting edge
    task automatic issue(logic [4:0] op, logic [31:0] a, logic [31:0] d);
        op_i = op; addr_i = a; data_i = d;
        @(posedge clk);
        @(negedge clk);
        op_i = '0;
    endtask

    function automatic logic [31:0] reg_val(int r);
        case (r)
            0: return m_tst;
            1: return 32'(m_stall);
            2: return 32'(m_cksel);
            3: return 32'(m_dly);
            default: return 32'(m_swdly);
        endcase
    endfunction

    task automatic reg_write(int r, logic [31:0] v);
        case (r)
            0: begin issue(5'd4, 0, v); m_tst = v; end
            1: begin issue(5'd6, 0, v); m_stall = v[3:0]; end
            2: begin issue(5'd8, 0, v); m_cksel = v[0]; end
            3: begin issue(5'd10, 0, v); m_dly = v[4:0]; end
            default: begin issue(5'd12, 0, v); m_swdly = v[0]; end
        endcase
    endtask

    task automatic reg_read(int r);
        logic [4:0] op;
        op = (r == 0) ? 5'd5 : (r == 1) ? 5'd7 : (r == 2) ? 5'd9 : (r == 3) ? 5'd11 : 5'd13;
        issue(op, 0, 0);
        check("R8 readback", jtag_rdata_o, reg_val(r));
        check("R8 no busy", busy_o, 0);
    endtask

    task automatic do_write(logic [31:0] a, logic [31:0] d);
        int n;
        n = (m_dly == 0) ? 1 : m_dly;
        issue(5'd2, a, d);
        for (int k = 0; k <= n + 1; k++) begin
            if (k < n) begin
                check("R3 wr high", cfg_wr_o, 1);
                check("R3 rd low", cfg_rd_o, 0);
                check("R3 addr", cfg_addr_o, a);
                check("R3 data", cfg_wdata_o, d);
            end else if (k == n) begin
                check("R3 wr tail", {cfg_wr_o, busy_o}, 2'b01);
            end else begin
                check("R3 done", busy_o, 0);
            end
            if (k <= n) @(negedge clk);
        end
    endtask

    task automatic do_read(logic [31:0] a, logic [31:0] fab);
        int n;
        n = (m_dly == 0) ? 1 : m_dly;
        cfg_rdata_i = fab;
        issue(5'd3, a, 0);
        for (int k = 0; k <= n + 1; k++) begin
            if (k < n) begin
                check("R4 rd high", {cfg_rd_o, cfg_wr_o}, 2'b10);
                check("R4 addr", cfg_addr_o, a);
            end else if (k == n) begin
                check("R4 rd tail", {cfg_rd_o, busy_o}, 2'b01);
            end else begin
                check("R4 data", jtag_rdata_o, fab);
                check("R4 done", busy_o, 0);
            end
            if (k <= n) @(negedge clk);
        end
    endtask

    task automatic do_adv(logic [3:0] mask, int d);
        int n;
        n = (d == 0) ? 1 : d;
        issue(5'd14, 32'(mask), 32'(d));
        for (int k = 0; k <= n + 1; k++) begin
            if (k < n) check("R6 released", stall_o, m_stall & ~mask);
            else if (k == n) check("R6 restored", {stall_o, busy_o}, {m_stall, 1'b1});
            else check("R6 done", {stall_o, busy_o}, {m_stall, 1'b0});
            if (k <= n) @(negedge clk);
        end
    endtask

    task automatic do_greset(int d);
        int n;
        n = (d == 0) ? 1 : d;
        issue(5'd15, 0, 32'(d));
        for (int k = 0; k <= n + 1; k++) begin
            if (k < n) check("R7 reset high", greset_o, 1);
            else if (k == n) check("R7 tail", {greset_o, busy_o}, 2'b01);
            else check("R7 done", busy_o, 0);
            if (k <= n) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_v;
        seed_v = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 stall", stall_o, 4'hF);
        check("R9 dly", rw_dly_o, 5'd1);
        check("R9 misc", {clk_sel_o, sw_dly_o, cfg_rd_o, cfg_wr_o, greset_o, busy_o}, 0);
        check("R9 jdata", jtag_rdata_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 bring-up
        issue(5'd1, 0, 0);
        check("R2 const", jtag_rdata_o, 32'hA050);
        check("R2 no busy", busy_o, 0);

        // R1 undefined codes are no-ops
        issue(5'd23, 32'hF, 32'h0);
        check("R1 undefined op", {stall_o, busy_o, jtag_rdata_o}, {4'hF, 1'b0, 32'hA050});

        do_read(32'h1234_5678, 32'hCAFE_F00D);   // R4 with delay 1
        do_write(32'h0000_0010, 32'h55AA_55AA);  // R3 with delay 1

        // R11 zero delay behaves as one
        reg_write(3, 0);
        check("R11 dly out", rw_dly_o, 0);
        do_write(32'h44, 32'h99);
        do_adv(4'b0101, 0);
        do_greset(0);

        reg_write(3, 5'd4);
        do_write(32'hDEAD_0001, 32'h0BAD_F00D);
        do_read(32'h0000_0BEE, 32'h1357_9BDF);

        // R1 op during busy is ignored
        issue(5'd2, 32'h8, 32'h9);
        op_i = 5'd4; data_i = 32'h7777_7777;
        @(negedge clk);
        op_i = 5'd0;
        repeat (5) @(negedge clk);
        check("R1 idle after write", busy_o, 0);
        reg_read(0);

        // R5 stall write
        reg_write(1, 32'h6);
        check("R5 stall now", {stall_o, busy_o}, {4'h6, 1'b0});
        do_adv(4'b0011, 5);
        do_adv(4'b1111, 3);
        do_greset(7);

        // R8 random register round-trips
        for (int i = 0; i < 40; i++) begin
            int r;
            r = $urandom_range(0, 4);
            if (r == 3) reg_write(r, $urandom_range(0, 8));
            else reg_write(r, $urandom);
            reg_read(r);
            check("R8 outputs", {clk_sel_o, sw_dly_o, rw_dly_o, stall_o}, {m_cksel, m_swdly, m_dly, m_stall});
        end
        for (int i = 0; i < 10; i++) begin
            do_write($urandom, $urandom);
            do_read($urandom, $urandom);
            do_adv(4'($urandom), $urandom_range(0, 12));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule